// File: doc/BRIEF.md
# Shared Gamma Correction Table

This block applies gamma correction to pixels from three display channels. One linear table memory holds a separate red, green and blue table for each channel, and a host fills it through a single streaming port. To start a fill, the host loads a start address together with an auto-increment flag. It then pushes table entries one by one through a data port. Each entry is an 8-bit output value indexed by an 8-bit input component.

The pixel stream is tagged with a channel number. In each cycle one pixel enters, and its three components are looked up in parallel. The memory is kept as three banks, one per colour component, and each bank covers every channel. When the tagged channel's enable bit is clear, or the tag names no channel, the pixel leaves unchanged. This gives the same result as an identity table. The result is registered, so there is one cycle of latency. A host write and a lookup in the same cycle do not stall each other. The write takes effect, and the lookup returns the table content from before that write.

Top module: `gamma_lut`

## Requirements
- R1: After reset, `pix_out_valid` is low, the write pointer is 0 and auto-increment is off. A data write issued before any address load therefore lands on address 0, and a second such write lands on address 0 again.
- R2: An address load sets the write pointer to `host_addr` and the auto-increment flag to `host_autoinc`. A loaded value of 2304 or more is taken as 0.
- R3: With auto-increment on, each data write stores one entry at the pointer and then advances the pointer by one.
- R4: With auto-increment off, repeated data writes all land on the same address, so the last write wins and the neighbouring entries are unchanged.
- R5: With auto-increment on, a data write at address 2303 is followed by the pointer wrapping to 0.
- R6: A linear address a maps to channel a/768, component (a mod 768)/256 (0 red, 1 green, 2 blue) and input index a mod 256.
- R7: When `pix_valid` is high and the tagged channel is enabled, `pix_out` one cycle later holds {R', G', B'}. Red occupies bits 23:16, green bits 15:8 and blue bits 7:0. Each component is the entry of that channel's table for that component at the input value. `pix_out_valid` is a one-cycle-delayed copy of `pix_valid`.
- R8: When the tagged channel's `gamma_en` bit is clear, or `pix_ch` is 3 (no channel), `pix_out` one cycle later equals `pix_in`.
- R9: When an address load and a data write arrive in the same cycle, the data is stored at the newly loaded address.
- R10: A lookup in the same cycle as a host write to the entry it reads returns the entry's previous value. Later lookups return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr_we | input | 1 | Load the write pointer and auto-increment flag |
| host_addr | input | 12 | Start address to load |
| host_autoinc | input | 1 | Auto-increment flag loaded with the address |
| host_data_we | input | 1 | Store one table entry |
| host_data | input | 8 | Table entry value |
| gamma_en | input | 3 | Per-channel table enable, bit n for channel n |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_ch | input | 2 | Channel tag of the pixel |
| pix_in | input | 24 | Input pixel {R, G, B} |
| pix_out_valid | output | 1 | Output pixel present |
| pix_out | output | 24 | Corrected or passed-through pixel {R, G, B} |

## Verification
Several properties are checked on every cycle:
- the write pointer always stays inside the table;
- the pointer steps by one, or wraps to 0, on each auto-incremented write;
- the pointer holds still on non-incremented writes;
- output validity follows input validity by one cycle;
- a bypassed pixel emerges unchanged.

The contents that lookups return can only be shown by the bench's scenarios. These are:
- a full table fill, followed by a sweep of every input value on every channel;
- last-write-wins at a fixed address;
- the wrap from the top address to 0;
- an out-of-range address load;
- a write that coincides with a lookup of the same entry.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
    localparam int NUM_CH  = 3;
    localparam int DATA_W  = 8;
    localparam int TAB_N   = 1 << DATA_W;
    localparam int COMP_N  = 3;
    localparam int CH_SPAN = TAB_N * COMP_N;
    localparam int TOTAL   = NUM_CH * CH_SPAN;
    localparam int ADDR_W  = $clog2(TOTAL);
    localparam int BANK_N  = NUM_CH * TAB_N;
    localparam int BANK_AW = $clog2(BANK_N);
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int PIX_W   = COMP_N * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] r;
        logic [DATA_W-1:0] g;
        logic [DATA_W-1:0] b;
    } pixel_t;

    // component (0 red, 1 green, 2 blue) selected by a linear address
    function automatic logic [1:0] comp_of(input logic [ADDR_W-1:0] a);
        int ai;
        ai = int'(a);
        return 2'((ai % CH_SPAN) / TAB_N);
    endfunction

    // location inside a component bank: channel * TAB_N + index
    function automatic logic [BANK_AW-1:0] bank_of(input logic [ADDR_W-1:0] a);
        int ai;
        ai = int'(a);
        return BANK_AW'((ai / CH_SPAN) * TAB_N + (ai % TAB_N));
    endfunction

    // channel enable lookup that is safe for tags naming no channel
    function automatic logic chan_enabled(input logic [NUM_CH-1:0] en,
                                          input logic [CH_W-1:0] ch);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_CH; i++)
            if (int'(ch) == i) r = en[i];
        return r;
    endfunction
endpackage

// File: rtl/gamma_ptr.sv
module gamma_ptr
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              autoinc_in,
    input  logic              data_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] ptr_q,
    output logic              autoinc_q
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TOTAL - 1);

    logic [ADDR_W-1:0] load_val;
    logic              inc_eff;

    assign load_val = (int'(addr_in) >= TOTAL) ? '0 : addr_in;
    assign wr_addr  = addr_we ? load_val : ptr_q;
    assign inc_eff  = addr_we ? autoinc_in : autoinc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            autoinc_q <= 1'b0;
        end else begin
            if (addr_we) autoinc_q <= autoinc_in;
            if (data_we && inc_eff)
                ptr_q <= (wr_addr == LAST) ? '0 : wr_addr + 1'b1;
            else if (addr_we)
                ptr_q <= load_val;
        end
    end
endmodule

// File: rtl/gamma_bank.sv
module gamma_bank #(
    parameter int DEPTH = 768,
    parameter int AW    = 10,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_addr_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_autoinc,
    input  logic              host_data_we,
    input  logic [DATA_W-1:0] host_data,
    input  logic [NUM_CH-1:0] gamma_en,
    input  logic              pix_valid,
    input  logic [CH_W-1:0]   pix_ch,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              pix_out_valid,
    output logic [PIX_W-1:0]  pix_out
);
    logic [ADDR_W-1:0]  wr_addr;
    logic [ADDR_W-1:0]  ptr_q;
    logic               autoinc_q;
    logic [1:0]         wr_comp;
    logic [BANK_AW-1:0] wr_bank;

    gamma_ptr u_ptr (
        .clk        (clk),
        .rst        (rst),
        .addr_we    (host_addr_we),
        .addr_in    (host_addr),
        .autoinc_in (host_autoinc),
        .data_we    (host_data_we),
        .wr_addr    (wr_addr),
        .ptr_q      (ptr_q),
        .autoinc_q  (autoinc_q)
    );

    assign wr_comp = comp_of(wr_addr);
    assign wr_bank = bank_of(wr_addr);

    pixel_t             pin;
    pixel_t             pin_q;
    logic               ch_ok;
    logic               pass_q;
    logic               vld_q;
    logic [DATA_W-1:0]  comp_in [COMP_N];
    logic [DATA_W-1:0]  lut_q   [COMP_N];
    logic [BANK_AW-1:0] rd_addr [COMP_N];

    assign pin        = pixel_t'(pix_in);
    assign comp_in[0] = pin.r;
    assign comp_in[1] = pin.g;
    assign comp_in[2] = pin.b;
    assign ch_ok      = int'(pix_ch) < NUM_CH;

    for (genvar k = 0; k < COMP_N; k++) begin : g_bank
        assign rd_addr[k] = ch_ok
            ? BANK_AW'(int'(pix_ch) * TAB_N + int'(comp_in[k])) : '0;

        gamma_bank #(.DEPTH(BANK_N), .AW(BANK_AW), .DW(DATA_W)) u_bank (
            .clk   (clk),
            .we    (host_data_we && (wr_comp == 2'(k))),
            .waddr (wr_bank),
            .wdata (host_data),
            .raddr (rd_addr[k]),
            .rdata (lut_q[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            pass_q <= 1'b1;
            pin_q  <= '0;
        end else begin
            vld_q  <= pix_valid;
            pass_q <= !chan_enabled(gamma_en, pix_ch);
            pin_q  <= pin;
        end
    end

    assign pix_out_valid = vld_q;
    assign pix_out       = pass_q ? PIX_W'(pin_q) : {lut_q[0], lut_q[1], lut_q[2]};
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk
    import gamma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_addr_we,
    input logic              host_data_we,
    input logic [NUM_CH-1:0] gamma_en,
    input logic              pix_valid,
    input logic [CH_W-1:0]   pix_ch,
    input logic [PIX_W-1:0]  pix_in,
    input logic              pix_out_valid,
    input logic [PIX_W-1:0]  pix_out,
    input logic [ADDR_W-1:0] ptr_q,
    input logic              autoinc_q
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TOTAL - 1);

    // R1: one cycle after reset the output is not valid
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> !pix_out_valid);

    // R2, R5: pointer never leaves the table
    a_r2_ptr_range: assert property (@(posedge clk) disable iff (rst)
        int'(ptr_q) < TOTAL);

    // R3, R5: increment with wrap
    a_r3_autoinc_step: assert property (@(posedge clk) disable iff (rst)
        host_data_we && !host_addr_we && autoinc_q
        |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

    // R4: pointer holds without auto-increment
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        host_data_we && !host_addr_we && !autoinc_q |=> $stable(ptr_q));

    // R7: validity follows input by one cycle
    a_r7_valid_follow: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> pix_out_valid);
    a_r7_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !pix_out_valid);

    // R8: bypassed pixel is unchanged
    a_r8_bypass: assert property (@(posedge clk) disable iff (rst)
        pix_valid && !chan_enabled(gamma_en, pix_ch)
        |=> pix_out == $past(pix_in));
endmodule

bind gamma_lut gamma_lut_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_addr_we  (host_addr_we),
    .host_data_we  (host_data_we),
    .gamma_en      (gamma_en),
    .pix_valid     (pix_valid),
    .pix_ch        (pix_ch),
    .pix_in        (pix_in),
    .pix_out_valid (pix_out_valid),
    .pix_out       (pix_out),
    .ptr_q         (ptr_q),
    .autoinc_q     (autoinc_q)
);

// File: tb/tb_gamma_lut.sv
module tb_gamma_lut;
    import gamma_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_addr_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic              host_autoinc = 1'b0;
    logic              host_data_we = 1'b0;
    logic [DATA_W-1:0] host_data = '0;
    logic [NUM_CH-1:0] gamma_en = '0;
    logic              pix_valid = 1'b0;
    logic [CH_W-1:0]   pix_ch = '0;
    logic [PIX_W-1:0]  pix_in = '0;
    logic              pix_out_valid;
    logic [PIX_W-1:0]  pix_out;

    always #2 clk = ~clk;

    gamma_lut dut (.*);

    int tests = 0;
    int fails = 0;
    logic [7:0] tab [TOTAL];
    int m_ptr = 0;
    bit m_inc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_addr(input int a, input bit inc);
        @(negedge clk);
        host_addr_we = 1'b1; host_addr = ADDR_W'(a); host_autoinc = inc;
        @(negedge clk);
        host_addr_we = 1'b0;
        m_ptr = (a >= TOTAL) ? 0 : a;
        m_inc = inc;
    endtask

    task automatic model_write(input logic [7:0] v);
        tab[m_ptr] = v;
        if (m_inc) m_ptr = (m_ptr == TOTAL - 1) ? 0 : m_ptr + 1;
    endtask

    task automatic put_data(input logic [7:0] v);
        @(negedge clk);
        host_data_we = 1'b1; host_data = v;
        @(negedge clk);
        host_data_we = 1'b0;
        model_write(v);
    endtask

    function automatic logic [23:0] expect_pix(input int ch, input logic [23:0] p, input logic [2:0] en);
        if (ch >= NUM_CH || !en[ch]) return p;
        return {tab[ch*CH_SPAN + int'(p[23:16])],
                tab[ch*CH_SPAN + TAB_N + int'(p[15:8])],
                tab[ch*CH_SPAN + 2*TAB_N + int'(p[7:0])]};
    endfunction

    task automatic lookup(input int ch, input logic [23:0] p, input logic [2:0] en, input string tag);
        logic [23:0] e;
        @(negedge clk);
        pix_valid = 1'b1; pix_ch = CH_W'(ch); pix_in = p; gamma_en = en;
        e = expect_pix(ch, p, en);
        @(negedge clk);
        pix_valid = 1'b0;
        chk(pix_out_valid === 1'b1, {tag, " valid"}, int'(pix_out_valid), 1);
        chk(pix_out === e, tag, int'(pix_out), int'(e));
    endtask

    function automatic logic [7:0] fill_val(input int a);
        return 8'((a * 37 + (a >> 8) * 11 + 3) & 255);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [23:0] p;
        repeat (3) @(negedge clk);
        chk(pix_out_valid === 1'b0, "R1 valid low in reset", int'(pix_out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pix_out_valid === 1'b0, "R1 valid low after reset", int'(pix_out_valid), 0);
        // R1: pointer 0, no auto-increment: both writes land on address 0
        put_data(8'h11);
        put_data(8'h22);
        lookup(0, 24'h000000, 3'b001, "R1 addr0 last write");
        chk(tab[1] !== 8'h22, "R1 no advance", 0, 0);

        // R2, R3, R6: full fill through auto-increment
        load_addr(0, 1'b1);
        for (int a = 0; a < TOTAL; a++) put_data(fill_val(a));

        // R6, R7: sweep each channel over every input value
        for (int ch = 0; ch < NUM_CH; ch++)
            for (int v = 0; v < TAB_N; v++) begin
                p = {8'(v), 8'((v + 85) & 255), 8'((v + 170) & 255)};
                lookup(ch, p, 3'b111, $sformatf("R7 R6 ch%0d v%0d", ch, v));
            end
        // R7: valid drops one cycle after pix_valid does
        @(negedge clk);
        chk(pix_out_valid === 1'b0, "R7 valid follows", int'(pix_out_valid), 0);

        // R8: bypass for disabled channels and channel tag 3
        for (int ch = 0; ch < 4; ch++)
            for (int v = 0; v < TAB_N; v += 17) begin
                p = {8'(v), 8'(255 - v), 8'((v * 3) & 255)};
                lookup(ch, p, (ch == 3) ? 3'b111 : ~(3'b001 << ch),
                       $sformatf("R8 bypass ch%0d v%0d", ch, v));
            end

        // R4: fixed address, last write wins, neighbour unchanged
        load_addr(CH_SPAN + TAB_N + 40, 1'b0);
        put_data(8'hA1); put_data(8'hB2); put_data(8'hC3);
        lookup(1, {8'd0, 8'd40, 8'd0}, 3'b010, "R4 last write wins");
        lookup(1, {8'd0, 8'd41, 8'd0}, 3'b010, "R4 neighbour kept");

        // R5: wrap from the top address to 0
        load_addr(TOTAL - 1, 1'b1);
        put_data(8'h5A); put_data(8'hA5);
        lookup(2, {8'd0, 8'd0, 8'd255}, 3'b100, "R5 top entry");
        lookup(0, {8'd0, 8'd0, 8'd0}, 3'b001, "R5 wrapped to 0");

        // R2: out-of-range load is taken as 0
        load_addr(2400, 1'b1);
        put_data(8'h3C);
        lookup(0, {8'd0, 8'd0, 8'd0}, 3'b001, "R2 out of range to 0");
        put_data(8'h4D);
        lookup(0, {8'd1, 8'd0, 8'd0}, 3'b001, "R2 R3 next after clamp");

        // R9: address load and data write in the same cycle
        @(negedge clk);
        host_addr_we = 1'b1; host_addr = ADDR_W'(2*CH_SPAN + 77); host_autoinc = 1'b1;
        host_data_we = 1'b1; host_data = 8'hE7;
        @(negedge clk);
        host_addr_we = 1'b0; host_data_we = 1'b0;
        m_ptr = 2*CH_SPAN + 77; m_inc = 1'b1;
        model_write(8'hE7);
        lookup(2, {8'd77, 8'd0, 8'd0}, 3'b100, "R9 same-cycle load");

        // R10: write and lookup of the same entry in one cycle
        load_addr(10, 1'b0);
        @(negedge clk);
        host_data_we = 1'b1; host_data = 8'h99;
        pix_valid = 1'b1; pix_ch = '0; pix_in = {8'd10, 8'd0, 8'd0}; gamma_en = 3'b001;
        p = expect_pix(0, {8'd10, 8'd0, 8'd0}, 3'b001);
        @(negedge clk);
        host_data_we = 1'b0; pix_valid = 1'b0;
        model_write(8'h99);
        chk(pix_out === p, "R10 old value on collision", int'(pix_out), int'(p));
        lookup(0, {8'd10, 8'd0, 8'd0}, 3'b001, "R10 new value after");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule